// File: doc/BRIEF.md
# PCI Abort Completion Handler

This block decides which completion a bus bridge returns to its host side once a PCI transaction that the bridge mastered has finished. The outbound request engine hands over one request at a time. Each request carries the transaction kind, the length in dwords, how the bus ended the transaction, and any read data. The handler turns that into a completion with a status of normal or hard fail and the data to return. It also raises one-cycle strobes that set the received-master-abort bit, the received-target-abort bit and the PCI first-error log bit in the bridge's status logic.

Master aborts are handled according to kind and length. A single-dword memory access finishes normally, and a read of that kind returns all-ones data. A longer memory access fails hard. A configuration access finishes normally whatever its length and is kept out of the first-error log. A target abort always fails hard. Requests come in through a valid/ready handshake. Completions leave through one registered stage that holds its contents while the host side applies back-pressure.

Top module: `acpl_handler`

## Requirements
- R1: A master-aborted memory read (kind 2'b00, term 2'b01) of length 1 completes with status 0 (normal) and all-ones data.
- R2: A master-aborted memory read longer than 1 dword completes with status 1 (hard fail) and zero data.
- R3: A master-aborted memory write (kind 2'b01) completes with status 0 when its length is 1 and with status 1 when its length is above 1, always with zero data.
- R4: A master-aborted configuration access (read 2'b10 or write 2'b11) of any length completes with status 0. A configuration read returns all-ones data and a configuration write returns zero data. The completion pulses set_rma and never pulses set_ferr.
- R5: Every master-aborted completion pulses set_rma and does not pulse set_rta. A master-aborted memory completion also pulses set_ferr.
- R6: A target-aborted access (term 2'b10) of any kind completes with status 1 and zero data, and pulses set_rta and set_ferr but not set_rma.
- R7: A normal termination (term 2'b00) completes with status 0 and raises no strobe. A read passes its data through unchanged and a write returns zero data.
- R8: A request is taken on a cycle with req_valid and req_ready both high, and its completion becomes valid on the following cycle. req_ready is high exactly when the output stage is empty or is being drained. While cpl_valid is high and cpl_ready is low, the completion's status and data stay unchanged.
- R9: The status strobes are high only in the cycle in which the completion is handed over (cpl_valid and cpl_ready), each for one cycle per completion.
- R10: While reset is held and after it is released, cpl_valid and all strobes are low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Handler can take a request |
| req_kind | input | 2 | 00 memory read, 01 memory write, 10 config read, 11 config write |
| req_term | input | 2 | 00 normal, 01 master abort, 10 target abort |
| req_len | input | LEN_W (10) | Transaction length in dwords, at least 1 |
| req_data | input | DATA_W (32) | Read data from the bus |
| cpl_valid | output | 1 | Completion present |
| cpl_ready | input | 1 | Host side takes the completion |
| cpl_status | output | 1 | 0 normal, 1 hard fail |
| cpl_data | output | DATA_W (32) | Completion data |
| set_rma | output | 1 | Pulse: set received-master-abort |
| set_rta | output | 1 | Pulse: set received-target-abort |
| set_ferr | output | 1 | Pulse: log PCI first error |

## Verification
The properties assume that a valid request never carries the unused termination code 2'b11 and never has a length of zero, and a checker property flags any request that breaks this. The stimulus keeps to these limits: every table entry and every directed request uses lengths of 1 or more and only the three defined termination codes. Requests are presented only while req_ready is high, and req_valid drops in the cycle after acceptance, so each completion can be matched to the single request that produced it.

// File: rtl/acpl_pkg.sv
// Shared encodings for the abort completion handler.
package acpl_pkg;
    typedef enum logic [1:0] {
        KIND_MRD = 2'b00,
        KIND_MWR = 2'b01,
        KIND_CRD = 2'b10,
        KIND_CWR = 2'b11
    } kind_e;

    typedef enum logic [1:0] {
        TERM_OK  = 2'b00,
        TERM_MA  = 2'b01,
        TERM_TA  = 2'b10,
        TERM_RSV = 2'b11
    } term_e;

    typedef enum logic {
        ST_NORMAL   = 1'b0,
        ST_HARDFAIL = 1'b1
    } cstat_e;

    typedef enum logic [1:0] {
        DSEL_PASS = 2'b00,
        DSEL_ONES = 2'b01,
        DSEL_ZERO = 2'b10
    } dsel_e;

    // Classified request attributes
    typedef struct packed {
        logic is_read;
        logic is_cfg;
        logic multi;
        logic ma;
        logic ta;
    } cls_t;

    // Resolved completion action
    typedef struct packed {
        cstat_e status;
        dsel_e  dsel;
        logic   rma;
        logic   rta;
        logic   ferr;
    } act_t;
endpackage

// File: rtl/acpl_classify.sv
// Decodes kind, termination and length into flags for the resolver.
// Assumes: len is at least 1; term 2'b11 is unused and is read as normal.
module acpl_classify #(
    parameter int LEN_W = 10
) (
    input  logic [1:0]       kind,
    input  logic [1:0]       term,
    input  logic [LEN_W-1:0] len,
    output acpl_pkg::cls_t   cls
);
    import acpl_pkg::*;

    localparam logic [LEN_W-1:0] ONE_DW = LEN_W'(1);

    // Flag decode
    always_comb begin
        cls.is_read = (kind == KIND_MRD) || (kind == KIND_CRD);
        cls.is_cfg  = (kind == KIND_CRD) || (kind == KIND_CWR);
        cls.multi   = (len > ONE_DW);
        cls.ma      = (term == TERM_MA);
        cls.ta      = (term == TERM_TA);
    end
endmodule

// File: rtl/acpl_resolve.sv
// Chooses the completion status, the data source and the status strobes
// from the classified request. Purely combinational.
module acpl_resolve (
    input  acpl_pkg::cls_t cls,
    output acpl_pkg::act_t act
);
    import acpl_pkg::*;

    // Abort policy: target abort first, then master abort by kind and length
    always_comb begin
        act.status = ST_NORMAL;
        act.dsel   = cls.is_read ? DSEL_PASS : DSEL_ZERO;
        act.rma    = 1'b0;
        act.rta    = 1'b0;
        act.ferr   = 1'b0;
        if (cls.ta) begin
            act.status = ST_HARDFAIL;
            act.dsel   = DSEL_ZERO;
            act.rta    = 1'b1;
            act.ferr   = 1'b1;
        end else if (cls.ma) begin
            act.rma = 1'b1;
            if (cls.is_cfg) begin
                act.dsel = cls.is_read ? DSEL_ONES : DSEL_ZERO;
            end else begin
                act.ferr = 1'b1;
                if (cls.multi) begin
                    act.status = ST_HARDFAIL;
                    act.dsel   = DSEL_ZERO;
                end else begin
                    act.dsel = cls.is_read ? DSEL_ONES : DSEL_ZERO;
                end
            end
        end
    end
endmodule

// File: rtl/acpl_out_stage.sv
// One-entry completion register with a valid/ready handshake. Applies the
// data selection on load and gates the strobes to the handover cycle.
// Assumes: upstream holds a request only until it is accepted.
module acpl_out_stage #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  acpl_pkg::act_t    in_act,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_status,
    output logic [DATA_W-1:0] out_data,
    output logic              out_rma,
    output logic              out_rta,
    output logic              out_ferr
);
    import acpl_pkg::*;

    logic              full_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] data_d;
    act_t              act_q;
    logic              load;
    logic              drain;

    // Handshake decode
    always_comb begin
        drain    = full_q && out_ready;
        in_ready = !full_q || out_ready;
        load     = in_valid && in_ready;
    end

    // Data substitution
    always_comb begin
        unique case (in_act.dsel)
            DSEL_ONES: data_d = '1;
            DSEL_ZERO: data_d = '0;
            default:   data_d = in_data;
        endcase
    end

    // Occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n)     full_q <= 1'b0;
        else if (load)  full_q <= 1'b1;
        else if (drain) full_q <= 1'b0;
    end

    // Payload capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            act_q  <= '0;
        end else if (load) begin
            data_q <= data_d;
            act_q  <= in_act;
        end
    end

    // Output drive and strobe gating
    always_comb begin
        out_valid  = full_q;
        out_status = act_q.status;
        out_data   = data_q;
        out_rma    = drain && act_q.rma;
        out_rta    = drain && act_q.rta;
        out_ferr   = drain && act_q.ferr;
    end
endmodule

// File: rtl/acpl_handler.sv
// Top level of the abort completion handler: classify, resolve, register.
// Assumes: requests carry len >= 1 and a defined termination code.
module acpl_handler #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [1:0]        req_term,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [DATA_W-1:0] req_data,
    output logic              cpl_valid,
    input  logic              cpl_ready,
    output logic              cpl_status,
    output logic [DATA_W-1:0] cpl_data,
    output logic              set_rma,
    output logic              set_rta,
    output logic              set_ferr
);
    import acpl_pkg::*;

    cls_t cls;
    act_t act;

    acpl_classify #(.LEN_W(LEN_W)) u_classify (
        .kind (req_kind),
        .term (req_term),
        .len  (req_len),
        .cls  (cls)
    );

    acpl_resolve u_resolve (
        .cls (cls),
        .act (act)
    );

    acpl_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (req_valid),
        .in_ready   (req_ready),
        .in_act     (act),
        .in_data    (req_data),
        .out_valid  (cpl_valid),
        .out_ready  (cpl_ready),
        .out_status (cpl_status),
        .out_data   (cpl_data),
        .out_rma    (set_rma),
        .out_rta    (set_rta),
        .out_ferr   (set_ferr)
    );
endmodule

// File: rtl/acpl_handler_chk.sv
// Property checker for acpl_handler, attached by bind.
module acpl_handler_chk #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_kind,
    input logic [1:0]        req_term,
    input logic [LEN_W-1:0]  req_len,
    input logic              cpl_valid,
    input logic              cpl_ready,
    input logic              cpl_status,
    input logic [DATA_W-1:0] cpl_data,
    input logic              set_rma,
    input logic              set_rta,
    input logic              set_ferr
);
    logic acc;
    assign acc = req_valid && req_ready;

    // Input assumption: defined termination and nonzero length
    p_legal_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_term != 2'b11) && (req_len != '0));

    p_ma_rd1_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_kind == 2'b00 && req_term == 2'b01 && req_len == LEN_W'(1))
        |=> cpl_valid && !cpl_status && (cpl_data == '1));

    p_ma_rdn_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_kind == 2'b00 && req_term == 2'b01 && req_len > LEN_W'(1))
        |=> cpl_valid && cpl_status && (cpl_data == '0));

    p_ma_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_kind == 2'b01 && req_term == 2'b01)
        |=> cpl_valid && (cpl_status == $past(req_len > LEN_W'(1))));

    p_ma_cfg_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_kind[1] && req_term == 2'b01) |=> cpl_valid && !cpl_status);

    p_ta_hf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_term == 2'b10) |=> cpl_valid && cpl_status && (cpl_data == '0));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && !cpl_ready) |=> cpl_valid && $stable(cpl_data) && $stable(cpl_status));

    p_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready == (!cpl_valid || cpl_ready));

    p_strobe_xfer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_rma || set_rta || set_ferr) |-> cpl_valid && cpl_ready);

    p_rma_rta_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_rma && set_rta));
endmodule

bind acpl_handler acpl_handler_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/acpl_handler_test.sv
module acpl_handler_test;
    localparam int DATA_W = 32;
    localparam int LEN_W  = 10;
    localparam int NVEC   = 12;
    localparam int VW     = 20;

    // Entry: {kind[2], term[2], len[10], status, dsel[2], rma, rta, ferr}
    // dsel: 0 pass-through, 1 all ones, 2 zero
    localparam logic [VW-1:0] VEC [NVEC] = '{
        {2'd0, 2'd1, 10'd1, 1'b0, 2'd1, 3'b101},  // R1
        {2'd0, 2'd1, 10'd4, 1'b1, 2'd2, 3'b101},  // R2
        {2'd1, 2'd1, 10'd1, 1'b0, 2'd2, 3'b101},  // R3
        {2'd1, 2'd1, 10'd2, 1'b1, 2'd2, 3'b101},  // R3
        {2'd2, 2'd1, 10'd1, 1'b0, 2'd1, 3'b100},  // R4
        {2'd3, 2'd1, 10'd1, 1'b0, 2'd2, 3'b100},  // R4
        {2'd2, 2'd1, 10'd3, 1'b0, 2'd1, 3'b100},  // R4
        {2'd0, 2'd2, 10'd1, 1'b1, 2'd2, 3'b011},  // R6
        {2'd1, 2'd2, 10'd8, 1'b1, 2'd2, 3'b011},  // R6
        {2'd2, 2'd2, 10'd1, 1'b1, 2'd2, 3'b011},  // R6
        {2'd0, 2'd0, 10'd2, 1'b0, 2'd0, 3'b000},  // R7
        {2'd1, 2'd0, 10'd1, 1'b0, 2'd2, 3'b000}   // R7
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        req_kind = '0;
    logic [1:0]        req_term = '0;
    logic [LEN_W-1:0]  req_len = LEN_W'(1);
    logic [DATA_W-1:0] req_data = '0;
    logic              cpl_valid;
    logic              cpl_ready = 1'b1;
    logic              cpl_status;
    logic [DATA_W-1:0] cpl_data;
    logic              set_rma, set_rta, set_ferr;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    acpl_handler #(.DATA_W(DATA_W), .LEN_W(LEN_W)) uut (.*);

    function automatic string vtag(int i);
        case (i)
            0: return "R1";
            1: return "R2";
            2, 3: return "R3";
            4, 5, 6: return "R4";
            7, 8, 9: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] k, input logic [1:0] t,
                        input logic [LEN_W-1:0] l, input logic [DATA_W-1:0] d);
        @(negedge clk);
        req_kind = k; req_term = t; req_len = l; req_data = d;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [DATA_W-1:0] exp_d;
        repeat (3) @(negedge clk);
        // R10: state while reset is held
        check(!cpl_valid && !set_rma && !set_rta && !set_ferr, "R10", "in reset",
              {cpl_valid, set_rma, set_rta, set_ferr}, 4'b0);
        check(req_ready, "R10", "ready in reset", req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(!cpl_valid && req_ready, "R10", "after reset",
              {cpl_valid, req_ready}, 2'b01);

        for (int i = 0; i < NVEC; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            cpl_ready = 1'b1;
            send(v[19:18], v[17:16], v[15:6], 32'hA500_0000 + i);
            case (v[4:3])
                2'd1: exp_d = '1;
                2'd2: exp_d = '0;
                default: exp_d = 32'hA500_0000 + i;
            endcase
            // R8: completion valid one cycle after acceptance
            check(cpl_valid, "R8", "valid after accept", cpl_valid, 1);
            check(cpl_status == v[5], vtag(i), "status", cpl_status, v[5]);
            check(cpl_data == exp_d, vtag(i), "data", cpl_data, exp_d);
            check({set_rma, set_rta, set_ferr} == v[2:0], vtag(i), "strobes",
                  {set_rma, set_rta, set_ferr}, v[2:0]);
            @(negedge clk);
            // R9: strobes last one cycle only
            check(!cpl_valid && !set_rma && !set_rta && !set_ferr, "R9", "pulse end",
                  {cpl_valid, set_rma, set_rta, set_ferr}, 4'b0);
        end

        // R8/R9: back-pressure on a master-aborted single read
        cpl_ready = 1'b0;
        send(2'd0, 2'd1, LEN_W'(1), 32'h1234_5678);
        check(cpl_valid && !req_ready, "R8", "stalled", {cpl_valid, req_ready}, 2'b10);
        check(!set_rma && !set_ferr, "R9", "no strobe while stalled",
              {set_rma, set_ferr}, 2'b00);
        repeat (3) @(negedge clk);
        check(cpl_valid && cpl_data == '1 && !cpl_status, "R8", "held data",
              cpl_data, 32'hFFFF_FFFF);
        cpl_ready = 1'b1;
        #1;
        check(set_rma && set_ferr && !set_rta && req_ready, "R9", "strobe at handover",
              {set_rma, set_rta, set_ferr, req_ready}, 4'b1011);
        @(negedge clk);
        check(!cpl_valid && !set_rma, "R9", "single pulse", {cpl_valid, set_rma}, 2'b00);

        // R5: longer config write master abort: rma, no ferr, normal
        send(2'd3, 2'd1, LEN_W'(5), 32'hDEAD_BEEF);
        check({cpl_status, set_rma, set_rta, set_ferr} == 4'b0100, "R5", "cfg write ma",
              {cpl_status, set_rma, set_rta, set_ferr}, 4'b0100);
        @(negedge clk);

        // R7: config read normal pass-through
        send(2'd2, 2'd0, LEN_W'(1), 32'h0BAD_F00D);
        check(cpl_data == 32'h0BAD_F00D && !cpl_status && !set_rma && !set_ferr,
              "R7", "cfg read pass", cpl_data, 32'h0BAD_F00D);
        @(negedge clk);

        // R10: reset while a completion is pending
        cpl_ready = 1'b0;
        send(2'd0, 2'd2, LEN_W'(1), 32'h1);
        rst_n = 1'b0;
        @(negedge clk);
        check(!cpl_valid && req_ready, "R10", "reset clears pending",
              {cpl_valid, req_ready}, 2'b01);
        rst_n = 1'b1;
        cpl_ready = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule